// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives the time-quantum tick and the per-bit timing strobes of a CAN controller from the system clock. A prescaler divides the system clock into quanta. A segment sequencer then counts quanta through a bit laid out as one synchronisation quantum, a propagation segment, a first phase segment and a second phase segment. It marks the sample point, the transmit point and the bit boundary with one-cycle strobes. The frame logic upstream supplies a bus-idle indication and the synchronised receive line.

A recessive-to-dominant edge (rx going from 1 to 0) while the bus is idle hard-synchronises the block. Both the bit and the prescaler restart from that edge. Inside a frame, such an edge resynchronises the bit. The block lengthens the first phase segment when the edge is late and shortens the second phase segment when it is early, and it never moves either by more than the programmed jump width. The configuration is checked continuously. An illegal setting raises `cfg_err` and freezes all timing until it is corrected.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `cfg_presc`+1 system clocks. `tq_tick` pulses for one cycle in the last clock of each quantum.
- R2: A bit holds 1 + `cfg_prop` + `cfg_ph1` + `cfg_ph2` quanta, numbered from 0 at the sync quantum. `sample_pt` pulses with the tick that ends quantum `cfg_prop`+`cfg_ph1`. `bit_start` pulses with the tick that ends the last quantum.
- R3: When `cfg_ph2` equals 2, `tx_pt` pulses with the tick that ends the sync quantum (quantum 0). For any other value, it pulses together with `bit_start`.
- R4: `cfg_err` is 1 whenever the quanta per bit are below 8 or above 25.
- R5: `cfg_err` is 1 whenever (`cfg_presc`+1) × quanta-per-bit is below 9 system clocks.
- R6: With `cfg_presc` = 0, a `cfg_ph2` of zero sets `cfg_err`.
- R7: `cfg_err` is 1 when `cfg_ph2` is below the processing time. That time is 3 quanta when `cfg_presc` = 0 and 2 quanta otherwise.
- R8: While `bus_idle` is 1, a 1-to-0 change of `rx` restarts the bit and reloads the prescaler. The first quantum after the edge is the sync quantum, and it begins in the next clock. No resynchronisation follows within that bit.
- R9: While `bus_idle` is 0, take an edge in quantum p of a bit, with 1 ≤ p ≤ `cfg_prop`+`cfg_ph1`. The block delays both the sample point and the bit end of that bit by min(p, `cfg_sjw`+1) quanta. It acts on at most one edge per bit.
- R10: While `bus_idle` is 0, take an edge in quantum p that lies after the sample quantum. The block ends the bit min(last−p, `cfg_sjw`+1) quanta early, where last is the index of the bit's last quantum.
- R11: While `cfg_err` is 1, none of `tq_tick`, `sample_pt`, `tx_pt` or `bit_start` fires.
- R12: `sampled_rx` resets to 1 and captures `rx` at each `sample_pt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_presc | input | PRESC_W | Clocks per quantum minus one |
| cfg_prop | input | SEG_W | Propagation segment length in quanta |
| cfg_ph1 | input | SEG_W | First phase segment length in quanta |
| cfg_ph2 | input | SEG_W | Second phase segment length in quanta |
| cfg_sjw | input | SJW_W | Jump width minus one |
| bus_idle | input | 1 | Frame logic reports an idle bus |
| rx | input | 1 | Synchronised receive line, 1 = recessive |
| tq_tick | output | 1 | Last clock of a quantum |
| sample_pt | output | 1 | Sample point strobe |
| tx_pt | output | 1 | Transmit point strobe |
| bit_start | output | 1 | Bit boundary strobe |
| sampled_rx | output | 1 | Bus value taken at the last sample point |
| cfg_err | output | 1 | Illegal timing configuration |

## Verification
The hardest state to reach is a soft resynchronisation. It needs the bus out of idle, a bit that has not already been synchronised, and a falling edge placed in a chosen quantum. A hard-sync bit always refuses resynchronisation, so a bit with a free synchronisation only exists from the second bit after a hard sync onward. The stimulus therefore hard-syncs first and drops the idle flag, then raises `rx` early in the second bit. It drops `rx` in the interval whose quantum index it computes from the prescaler period. This covers both a late edge in the propagation segment and an early edge in the second phase segment, with the jump width limiting the first case and the remaining quanta limiting the second.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC,
    SEG_PROP,
    SEG_PH1,
    SEG_PH2
  } seg_e;

  localparam int unsigned IPT_ONE_CLK   = 3;
  localparam int unsigned IPT_MULTI_CLK = 2;

  // quanta in one bit: sync + prop + ph1 + ph2
  function automatic int unsigned quanta_per_bit(input int unsigned prop,
                                                 input int unsigned ph1,
                                                 input int unsigned ph2);
    return 1 + prop + ph1 + ph2;
  endfunction

  // information processing time in quanta
  function automatic int unsigned proc_time(input int unsigned presc);
    return (presc == 0) ? IPT_ONE_CLK : IPT_MULTI_CLK;
  endfunction

  function automatic int unsigned clocks_per_bit(input int unsigned presc,
                                                 input int unsigned tq);
    return (presc + 1) * tq;
  endfunction

  function automatic int unsigned umin(input int unsigned a,
                                       input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/cbt_cfg_check.sv
`timescale 1ns/1ps
module cbt_cfg_check
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int SEG_W   = 4,
  parameter int POS_W   = 6,
  parameter int MIN_TQ  = 8,
  parameter int MAX_TQ  = 25,
  parameter int MIN_CLK = 9
) (
  input  logic [PRESC_W-1:0] presc,
  input  logic [SEG_W-1:0]   prop,
  input  logic [SEG_W-1:0]   ph1,
  input  logic [SEG_W-1:0]   ph2,
  output logic [POS_W-1:0]   tq_total,
  output logic               cfg_err
);

  int unsigned tq;
  int unsigned clks;
  logic bad_range, bad_clocks, bad_zero_ph2, bad_ipt;

  always_comb begin
    tq           = quanta_per_bit(32'(prop), 32'(ph1), 32'(ph2));
    clks         = clocks_per_bit(32'(presc), tq);
    bad_range    = (tq < 32'(MIN_TQ)) || (tq > 32'(MAX_TQ));
    bad_clocks   = clks < 32'(MIN_CLK);
    bad_zero_ph2 = (presc == '0) && (ph2 == '0);
    bad_ipt      = 32'(ph2) < proc_time(32'(presc));
    tq_total     = POS_W'(tq);
    cfg_err      = bad_range | bad_clocks | bad_zero_ph2 | bad_ipt;
  end

endmodule

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic               run,
  input  logic               reload,
  output logic               tq_tick
);

  logic [PRESC_W-1:0] cnt_q;
  logic               at_end;

  assign at_end  = cnt_q >= presc;
  assign tq_tick = run & ~reload & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || reload)  cnt_q <= '0;
    else if (at_end)          cnt_q <= '0;
    else                      cnt_q <= cnt_q + PRESC_W'(1);
  end

  // R1
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && presc != '0) |=> (!tq_tick || !$stable(presc)));

endmodule

// File: rtl/cbt_bit_seq.sv
`timescale 1ns/1ps
module cbt_bit_seq
  import cbt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 2,
  parameter int POS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tq_tick,
  input  logic             hard_sync,
  input  logic             soft_edge,
  input  logic             rx,
  input  logic [SEG_W-1:0] prop,
  input  logic [SEG_W-1:0] ph1,
  input  logic [SEG_W-1:0] ph2,
  input  logic [SJW_W-1:0] sjw,
  input  logic [POS_W-1:0] tq_total,
  output logic             sample_pt,
  output logic             tx_pt,
  output logic             bit_start,
  output logic             sampled_rx
);

  logic [POS_W-1:0] pos_q, ext_q, shr_q;
  logic             synced_q, sampled_q;
  logic [POS_W-1:0] sjw_len, samp_base, end_base, ext_new, shr_new;
  logic [POS_W-1:0] samp_pos, end_pos;
  logic             late_edge, early_edge, ph2_is_two;
  seg_e             seg;

  always_comb begin
    sjw_len   = POS_W'(sjw) + POS_W'(1);
    samp_base = POS_W'(prop) + POS_W'(ph1) + ext_q;
    end_base  = tq_total - POS_W'(1) + ext_q;
    if (pos_q == '0)                 seg = SEG_SYNC;
    else if (pos_q <= POS_W'(prop))  seg = SEG_PROP;
    else if (pos_q <= samp_base)     seg = SEG_PH1;
    else                             seg = SEG_PH2;
    late_edge  = soft_edge && !synced_q && (seg == SEG_PROP || seg == SEG_PH1);
    early_edge = soft_edge && !synced_q && (seg == SEG_PH2);
    ext_new    = POS_W'(umin(32'(pos_q), 32'(sjw_len)));
    shr_new    = POS_W'(umin(32'(end_base - pos_q), 32'(sjw_len)));
    samp_pos   = late_edge ? samp_base + ext_new : samp_base;
    if (late_edge)       end_pos = end_base + ext_new;
    else if (early_edge) end_pos = end_base - shr_new;
    else                 end_pos = end_base - shr_q;
    ph2_is_two = (ph2 == SEG_W'(2));
  end

  assign sample_pt  = tq_tick && (pos_q == samp_pos);
  assign bit_start  = tq_tick && (pos_q == end_pos);
  assign tx_pt      = ph2_is_two ? (tq_tick && seg == SEG_SYNC) : bit_start;
  assign sampled_rx = sampled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      ext_q     <= '0;
      shr_q     <= '0;
      synced_q  <= 1'b0;
      sampled_q <= 1'b1;
    end else begin
      if (sample_pt) sampled_q <= rx;
      if (!run || hard_sync) begin
        pos_q    <= '0;
        ext_q    <= '0;
        shr_q    <= '0;
        synced_q <= hard_sync;
      end else if (bit_start) begin
        pos_q    <= '0;
        ext_q    <= '0;
        shr_q    <= '0;
        synced_q <= 1'b0;
      end else begin
        if (late_edge) begin
          ext_q    <= ext_new;
          synced_q <= 1'b1;
        end
        if (early_edge) begin
          shr_q    <= shr_new;
          synced_q <= 1'b1;
        end
        if (tq_tick) pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // R2
  sample_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> !bit_start);

  // R8
  hs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_sync |=> !bit_start);

  // R9
  late_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_edge |=> (ext_q != '0));

endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
  import cbt_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int SEG_W   = 4,
  parameter int SJW_W   = 2,
  parameter int MIN_TQ  = 8,
  parameter int MAX_TQ  = 25,
  parameter int MIN_CLK = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic [SEG_W-1:0]   cfg_prop,
  input  logic [SEG_W-1:0]   cfg_ph1,
  input  logic [SEG_W-1:0]   cfg_ph2,
  input  logic [SJW_W-1:0]   cfg_sjw,
  input  logic               bus_idle,
  input  logic               rx,
  output logic               tq_tick,
  output logic               sample_pt,
  output logic               tx_pt,
  output logic               bit_start,
  output logic               sampled_rx,
  output logic               cfg_err
);

  localparam int POS_W = SEG_W + 2;

  logic [POS_W-1:0] tq_total;
  logic rx_q, fall, run, hard_sync, soft_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx;
  end

  assign fall      = rx_q & ~rx;
  assign run       = ~cfg_err;
  assign hard_sync = run & fall & bus_idle;
  assign soft_edge = run & fall & ~bus_idle;

  cbt_cfg_check #(
    .PRESC_W(PRESC_W), .SEG_W(SEG_W), .POS_W(POS_W),
    .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ), .MIN_CLK(MIN_CLK)
  ) u_cfg (
    .presc(cfg_presc), .prop(cfg_prop), .ph1(cfg_ph1), .ph2(cfg_ph2),
    .tq_total(tq_total), .cfg_err(cfg_err)
  );

  cbt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .presc(cfg_presc), .run(run),
    .reload(hard_sync), .tq_tick(tq_tick)
  );

  cbt_bit_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tq_tick(tq_tick),
    .hard_sync(hard_sync), .soft_edge(soft_edge), .rx(rx),
    .prop(cfg_prop), .ph1(cfg_ph1), .ph2(cfg_ph2), .sjw(cfg_sjw),
    .tq_total(tq_total), .sample_pt(sample_pt), .tx_pt(tx_pt),
    .bit_start(bit_start), .sampled_rx(sampled_rx)
  );

  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !(tq_tick || sample_pt || tx_pt || bit_start));

  // R7
  ipt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> (32'(cfg_ph2) >= ((cfg_presc == '0) ? 32'd3 : 32'd2)));

  // R6
  zero_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_presc == '0 && cfg_ph2 == '0) |-> cfg_err);

endmodule

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_presc;
  logic [3:0] cfg_prop, cfg_ph1, cfg_ph2;
  logic [1:0] cfg_sjw;
  logic       bus_idle, rx;
  logic       tq_tick, sample_pt, tx_pt, bit_start, sampled_rx, cfg_err;

  always #2 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_prop(cfg_prop),
    .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2), .cfg_sjw(cfg_sjw),
    .bus_idle(bus_idle), .rx(rx), .tq_tick(tq_tick), .sample_pt(sample_pt),
    .tx_pt(tx_pt), .bit_start(bit_start), .sampled_rx(sampled_rx),
    .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic [31:0] t;
    logic [2:0]  m;
  } exp_t;

  exp_t  sbq[$];
  exp_t  mon_it;
  logic [2:0] mon_m;
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  int    win_lo = -1, win_hi = -2;
  int    ticks = 0, exp_ticks = 0;
  bit    quiet = 0;
  int    quiet_hits = 0;
  string cur_req = "R2";
  int    P, prop_v, ph1_v, ph2_v, sjw_v, tot;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: mask bit0 sample, bit1 tx, bit2 boundary
  always @(negedge clk) begin
    if (cyc >= win_lo && cyc <= win_hi) begin
      mon_m = {bit_start, tx_pt, sample_pt};
      if (tq_tick) ticks++;
      if (mon_m != 3'b000) begin
        if (sbq.size() == 0) begin
          check(1'b0, cur_req, "unexpected strobe mask", int'(mon_m), 0);
        end else begin
          mon_it = sbq.pop_front();
          check(mon_it.t == 32'(cyc), cur_req, "strobe cycle",
                cyc, int'(mon_it.t));
          check(mon_it.m == mon_m, cur_req, "strobe mask",
                int'(mon_m), int'(mon_it.m));
        end
      end
    end
    if (quiet && (tq_tick || sample_pt || tx_pt || bit_start)) quiet_hits++;
  end

  task automatic drive_step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_iv(input int target);
    while (cyc < target) drive_step();
  endtask

  task automatic set_cfg(input int presc, input int prop, input int ph1,
                         input int ph2, input int sjwl);
    drive_step();
    cfg_presc = 8'(presc);
    cfg_prop  = 4'(prop);
    cfg_ph1   = 4'(ph1);
    cfg_ph2   = 4'(ph2);
    cfg_sjw   = 2'(sjwl - 1);
    P = presc + 1; prop_v = prop; ph1_v = ph1; ph2_v = ph2; sjw_v = sjwl;
    tot = 1 + prop + ph1 + ph2;
  endtask

  // falling edge while idle; returns the first interval of the new bit
  task automatic hard_start(output int e);
    drive_step();
    rx = 1'b1; bus_idle = 1'b1;
    repeat (3) drive_step();
    rx = 1'b0;
    e = cyc + 1;
  endtask

  // driver: expected strobes of nbits bits, resync in bit rbit at quantum epos
  task automatic sched(input int e, input int nbits, input int rbit,
                       input int epos);
    int base;
    int qt;
    base = 0; qt = 0;
    for (int b = 0; b < nbits; b++) begin
      int samp;
      int last;
      samp = prop_v + ph1_v;
      last = tot - 1;
      if (b == rbit) begin
        if (epos <= prop_v + ph1_v) begin
          int x;
          x = (epos < sjw_v) ? epos : sjw_v;
          samp += x; last += x;
        end else begin
          int r;
          r = tot - 1 - epos;
          last -= (r < sjw_v) ? r : sjw_v;
        end
      end
      for (int q = 0; q <= last; q++) begin
        logic [2:0] m;
        m[0] = (q == samp);
        m[1] = (ph2_v == 2) ? (q == 0) : (q == last);
        m[2] = (q == last);
        if (m != 3'b000) sbq.push_back('{t: 32'(e + base + q * P + P - 1), m: m});
      end
      base += (last + 1) * P;
      qt   += last + 1;
    end
    ticks = 0; exp_ticks = qt;
    win_lo = e; win_hi = e + base - 1;
  endtask

  task automatic close_window(input string req);
    wait_iv(win_hi + 2);
    check(sbq.size() == 0, req, "missing strobes", sbq.size(), 0);
    // R1: one tick per quantum in the window
    check(ticks == exp_ticks, "R1", "tick count", ticks, exp_ticks);
    sbq.delete();
    win_lo = -1; win_hi = -2;
  endtask

  task automatic cfg_case(input int presc, input int prop, input int ph1,
                          input int ph2, input bit exp, input string req);
    set_cfg(presc, prop, ph1, ph2, 1);
    #1;
    check(cfg_err == exp, req, "cfg_err", int'(cfg_err), int'(exp));
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e;
    rst_n = 1'b0; rx = 1'b1; bus_idle = 1'b1;
    cfg_presc = 8'd2; cfg_prop = 4'd2; cfg_ph1 = 4'd3; cfg_ph2 = 4'd2;
    cfg_sjw = 2'd0;
    repeat (4) @(posedge clk);
    #1;
    // R12 reset state
    check(sampled_rx == 1'b1, "R12", "sampled_rx at reset", int'(sampled_rx), 1);
    check({tq_tick, sample_pt, tx_pt, bit_start} == 4'b0000, "R12",
          "strobes at reset", int'({tq_tick, sample_pt, tx_pt, bit_start}), 0);
    rst_n = 1'b1;

    // A: 8 quanta of 3 clocks, ph2 = 2 moves tx to end of sync (R3, R8)
    cur_req = "R3";
    set_cfg(2, 2, 3, 2, 1);
    hard_start(e);
    sched(e, 3, -1, 0);
    drive_step(); bus_idle = 1'b0;
    close_window("R3");
    check(sampled_rx == 1'b0, "R12", "sampled_rx after dominant", int'(sampled_rx), 0);

    // B: 12 quanta of 2 clocks, late edge at quantum 3 of bit 1, sjw 2 (R9)
    cur_req = "R9";
    set_cfg(1, 3, 4, 4, 2);
    hard_start(e);
    sched(e, 4, 1, 3);
    drive_step(); bus_idle = 1'b0;
    wait_iv(e + 12 * 2 + 1); rx = 1'b1;
    wait_iv(e + 12 * 2 + 3 * 2); rx = 1'b0;
    close_window("R9");

    // C: 24 quanta of 1 clock, early edge at quantum 20 of bit 1, sjw 4 (R10)
    cur_req = "R10";
    set_cfg(0, 8, 8, 7, 4);
    hard_start(e);
    sched(e, 4, 1, 20);
    drive_step(); bus_idle = 1'b0;
    wait_iv(e + 24 + 5); rx = 1'b1;
    wait_iv(e + 24 + 20); rx = 1'b0;
    close_window("R10");

    // R11: illegal setting freezes timing
    cfg_case(0, 1, 3, 2, 1'b1, "R11");
    quiet = 1;
    repeat (40) drive_step();
    quiet = 0;
    check(quiet_hits == 0, "R11", "strobes while cfg_err", quiet_hits, 0);

    // R4 quanta range
    cfg_case(1, 1, 3, 2, 1'b1, "R4");
    cfg_case(1, 0, 3, 4, 1'b0, "R4");
    cfg_case(1, 8, 8, 8, 1'b0, "R4");
    cfg_case(1, 8, 8, 9, 1'b1, "R4");
    // R5 clocks-per-bit floor
    cfg_case(0, 2, 2, 3, 1'b1, "R5");
    cfg_case(0, 2, 3, 3, 1'b0, "R5");
    // R6 zero phase-2 with one-clock quantum
    cfg_case(0, 6, 6, 0, 1'b1, "R6");
    // R7 processing time
    cfg_case(1, 6, 6, 0, 1'b1, "R7");
    cfg_case(0, 5, 5, 2, 1'b1, "R7");
    cfg_case(1, 5, 5, 2, 1'b0, "R7");
    cfg_case(0, 5, 4, 3, 1'b0, "R7");
    cfg_case(1, 5, 5, 1, 1'b1, "R7");

    repeat (4) drive_step();
    finish_run();
  end

endmodule